// File: doc/BRIEF.md
# Single-Bit Accumulating Logic Unit

This block executes one family of 32-bit instructions. Each instruction picks one bit out of a first source register and one bit out of a second source register. It combines the two bits with one of four logic operations and then ANDs that result into bit 0 of a destination register. The upper 31 bits of the destination stay as they were. Because the new bit 0 can only hold or fall, a chain of these instructions builds a running "all conditions held" flag in the destination.

The unit holds a 16 x 32 register file. A load port fills it and a combinational debug port reads it back. On each clock the unit accepts at most one valid instruction word. It reads the two sources and the destination, computes the new bit 0 and writes the destination back on the same edge. A valid word whose primary opcode does not match is reported as illegal and changes nothing. The four arithmetic status flags are kept as a register that this family never writes.

Top module: `bitacc_unit`

## Requirements
- R1: A word is decoded as follows. Bits 7:0 hold the primary opcode, which must be 0x47. Bits 11:8 select source A, bits 15:12 select source B and bits 31:28 select the destination C. Bits 20:16 give the bit position in A, bits 27:23 give the bit position in B, and bits 22:21 give the operation code.
- R2: Operation code 0 forms the inner term as bitA AND bitB.
- R3: Operation code 1 forms the inner term as bitA OR bitB.
- R4: Operation code 2 forms the inner term as NOT(bitA OR bitB).
- R5: Operation code 3 forms the inner term as bitA AND NOT bitB.
- R6: The new C bit 0 equals the old C bit 0 ANDed with the inner term. Once it is 0, it stays 0 under further instructions.
- R7: Bits 31:1 of C are written back unchanged, and no register other than C changes.
- R8: A word with instr_valid high whose bits 7:0 are not 0x47 makes illegal_o high for exactly the one cycle after the edge that accepted it. Such a word writes no register.
- R9: While instr_valid is low, the word is ignored: no register changes and illegal_o stays low.
- R10: Synchronous reset clears every register and illegal_o.
- R11: load_en writes load_data into register load_idx at the rising edge. dbg_data shows register dbg_idx combinationally.
- R12: flags_o (bit 0 carry, bit 1 overflow, bit 2 sticky overflow, bit 3 advance overflow) stays 0 through every instruction.
- R13: When C is also source A or source B, the operands are the values from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| load_en | input | 1 | Register load strobe |
| load_idx | input | 4 | Register index to load |
| load_data | input | 32 | Value to load |
| instr_valid | input | 1 | Instruction word present this cycle |
| instr_word | input | 32 | Instruction word |
| illegal_o | output | 1 | One-cycle illegal-word indication |
| flags_o | output | 4 | Status flags, never written by this family |
| dbg_idx | input | 4 | Debug read index |
| dbg_data | output | 32 | Debug read data |

## Verification
The checker assumes that load_en and instr_valid are never high together. A legal instruction and a load would then compete for the single write port, and the no-write and write-index properties would lose their meaning. The stimulus keeps this assumption by loading the registers in separate cycles before each instruction is issued. It also holds instr_valid low while the loads run.

// File: rtl/bitacc_pkg.sv
package bitacc_pkg;

    localparam int unsigned XLEN    = 32;
    localparam int unsigned NREG    = 16;
    localparam int unsigned RIDX_W  = $clog2(NREG);
    localparam int unsigned POS_W   = $clog2(XLEN);
    localparam int unsigned NFLAGS  = 4;
    localparam logic [7:0]  OPC_BITACC = 8'h47;

    typedef enum logic [1:0] {
        SUB_AND  = 2'd0,
        SUB_OR   = 2'd1,
        SUB_NOR  = 2'd2,
        SUB_ANDN = 2'd3
    } sub_e;

    // Packed from MSB to LSB, matching the instruction word layout.
    typedef struct packed {
        logic [RIDX_W-1:0] rc;
        logic [POS_W-1:0]  pos_b;
        sub_e              sub;
        logic [POS_W-1:0]  pos_a;
        logic [RIDX_W-1:0] rb;
        logic [RIDX_W-1:0] ra;
        logic [7:0]        opc;
    } word_t;

    typedef struct packed {
        logic              illegal;
        logic [NFLAGS-1:0] flags;
    } ctl_t;

endpackage

// File: rtl/bitacc_decode.sv
module bitacc_decode
    import bitacc_pkg::*;
(
    input  logic              valid_i,
    input  logic [XLEN-1:0]   word_i,
    output logic [RIDX_W-1:0] ra_o,
    output logic [RIDX_W-1:0] rb_o,
    output logic [RIDX_W-1:0] rc_o,
    output logic [POS_W-1:0]  pa_o,
    output logic [POS_W-1:0]  pb_o,
    output sub_e              sub_o,
    output logic              exec_o,
    output logic              illegal_o
);

    word_t w;
    logic  opc_hit;

    always_comb begin
        w         = word_t'(word_i);
        opc_hit   = (w.opc == OPC_BITACC);
        ra_o      = w.ra;
        rb_o      = w.rb;
        rc_o      = w.rc;
        pa_o      = w.pos_a;
        pb_o      = w.pos_b;
        sub_o     = w.sub;
        exec_o    = valid_i & opc_hit;
        illegal_o = valid_i & ~opc_hit;
    end

endmodule

// File: rtl/bitacc_bitop.sv
module bitacc_bitop
    import bitacc_pkg::*;
#(
    parameter int unsigned W  = XLEN,
    localparam int unsigned PW = $clog2(W)
) (
    input  logic [W-1:0]  a_i,
    input  logic [W-1:0]  b_i,
    input  logic [W-1:0]  c_i,
    input  logic [PW-1:0] pa_i,
    input  logic [PW-1:0] pb_i,
    input  sub_e          sub_i,
    output logic [W-1:0]  c_o
);

    logic bit_a;
    logic bit_b;
    logic inner;

    always_comb begin
        bit_a = a_i[pa_i];
        bit_b = b_i[pb_i];
        unique case (sub_i)
            SUB_AND:  inner = bit_a & bit_b;
            SUB_OR:   inner = bit_a | bit_b;
            SUB_NOR:  inner = ~(bit_a | bit_b);
            SUB_ANDN: inner = bit_a & ~bit_b;
            default:  inner = 1'b0;
        endcase
        c_o = {c_i[W-1:1], c_i[0] & inner};
    end

endmodule

// File: rtl/bitacc_regfile.sv
module bitacc_regfile #(
    parameter int unsigned NR  = 16,
    parameter int unsigned W   = 32,
    parameter int unsigned NRD = 4,
    localparam int unsigned IW = $clog2(NR)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   we_i,
    input  logic [IW-1:0]          widx_i,
    input  logic [W-1:0]           wdata_i,
    input  logic [NRD-1:0][IW-1:0] ridx_i,
    output logic [NRD-1:0][W-1:0]  rdata_o
);

    logic [W-1:0] rf_d [NR];
    logic [W-1:0] rf_q [NR];

    always_comb begin
        for (int i = 0; i < NR; i++) begin
            rf_d[i] = rf_q[i];
        end
        if (we_i) begin
            rf_d[widx_i] = wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NR; i++) begin
                rf_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NR; i++) begin
                rf_q[i] <= rf_d[i];
            end
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata_o[p] = rf_q[ridx_i[p]];
    end

endmodule

// File: rtl/bitacc_unit.sv
module bitacc_unit
    import bitacc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic [RIDX_W-1:0] load_idx,
    input  logic [XLEN-1:0]   load_data,
    input  logic              instr_valid,
    input  logic [XLEN-1:0]   instr_word,
    output logic              illegal_o,
    output logic [NFLAGS-1:0] flags_o,
    input  logic [RIDX_W-1:0] dbg_idx,
    output logic [XLEN-1:0]   dbg_data
);

    localparam int unsigned NRD   = 4;
    localparam int unsigned RP_A  = 0;
    localparam int unsigned RP_B  = 1;
    localparam int unsigned RP_C  = 2;
    localparam int unsigned RP_DB = 3;

    logic [RIDX_W-1:0] ra, rb, rc;
    logic [POS_W-1:0]  pa, pb;
    sub_e              sub;
    logic              exec, bad_word;

    logic [NRD-1:0][RIDX_W-1:0] ridx;
    logic [NRD-1:0][XLEN-1:0]   rdata;

    logic [XLEN-1:0]   c_new;
    logic              wr_en;
    logic [RIDX_W-1:0] wr_idx;
    logic [XLEN-1:0]   wr_data;

    ctl_t ctl_d, ctl_q;

    bitacc_decode u_dec (
        .valid_i   (instr_valid),
        .word_i    (instr_word),
        .ra_o      (ra),
        .rb_o      (rb),
        .rc_o      (rc),
        .pa_o      (pa),
        .pb_o      (pb),
        .sub_o     (sub),
        .exec_o    (exec),
        .illegal_o (bad_word)
    );

    always_comb begin
        ridx[RP_A]  = ra;
        ridx[RP_B]  = rb;
        ridx[RP_C]  = rc;
        ridx[RP_DB] = dbg_idx;
    end

    bitacc_regfile #(
        .NR  (NREG),
        .W   (XLEN),
        .NRD (NRD)
    ) u_rf (
        .clk     (clk),
        .rst     (rst),
        .we_i    (wr_en),
        .widx_i  (wr_idx),
        .wdata_i (wr_data),
        .ridx_i  (ridx),
        .rdata_o (rdata)
    );

    bitacc_bitop #(
        .W (XLEN)
    ) u_op (
        .a_i   (rdata[RP_A]),
        .b_i   (rdata[RP_B]),
        .c_i   (rdata[RP_C]),
        .pa_i  (pa),
        .pb_i  (pb),
        .sub_i (sub),
        .c_o   (c_new)
    );

    // A legal instruction owns the write port; a load takes it otherwise.
    always_comb begin
        wr_en   = exec | load_en;
        wr_idx  = exec ? rc    : load_idx;
        wr_data = exec ? c_new : load_data;
    end

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.illegal = bad_word;
        ctl_d.flags   = ctl_q.flags;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign illegal_o = ctl_q.illegal;
    assign flags_o   = ctl_q.flags;
    assign dbg_data  = rdata[RP_DB];

endmodule

// File: rtl/bitacc_chk.sv
module bitacc_chk
    import bitacc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              instr_valid,
    input  logic [XLEN-1:0]   instr_word,
    input  logic              load_en,
    input  logic              illegal_o,
    input  logic              exec,
    input  logic              wr_en,
    input  logic [RIDX_W-1:0] wr_idx,
    input  logic [XLEN-1:0]   wr_data,
    input  logic [XLEN-1:0]   c_old
);

    logic opc_ok;
    assign opc_ok = (instr_word[7:0] == OPC_BITACC);

    assert_illegal_raised_R8: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && !opc_ok) |=> illegal_o);

    assert_illegal_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !(instr_valid && !opc_ok) |=> !illegal_o);

    assert_illegal_nowrite_R8: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && !opc_ok && !load_en) |-> !wr_en);

    assert_dest_index_R1: assert property (@(posedge clk) disable iff (rst)
        exec |-> (wr_idx == instr_word[31:28]));

    assert_upper_kept_R7: assert property (@(posedge clk) disable iff (rst)
        exec |-> (wr_data[XLEN-1:1] == c_old[XLEN-1:1]));

    assert_never_sets_R6: assert property (@(posedge clk) disable iff (rst)
        (exec && !c_old[0]) |-> !wr_data[0]);

endmodule

bind bitacc_unit bitacc_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .instr_valid (instr_valid),
    .instr_word  (instr_word),
    .load_en     (load_en),
    .illegal_o   (illegal_o),
    .exec        (exec),
    .wr_en       (wr_en),
    .wr_idx      (wr_idx),
    .wr_data     (wr_data),
    .c_old       (rdata[2])
);

// File: tb/bitacc_unit_tb_top.sv
module bitacc_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_en = 1'b0;
    logic [3:0]  load_idx = '0;
    logic [31:0] load_data = '0;
    logic        instr_valid = 1'b0;
    logic [31:0] instr_word = '0;
    logic        illegal_o;
    logic [3:0]  flags_o;
    logic [3:0]  dbg_idx = '0;
    logic [31:0] dbg_data;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    bitacc_unit dut_i (
        .clk         (clk),
        .rst         (rst),
        .load_en     (load_en),
        .load_idx    (load_idx),
        .load_data   (load_data),
        .instr_valid (instr_valid),
        .instr_word  (instr_word),
        .illegal_o   (illegal_o),
        .flags_o     (flags_o),
        .dbg_idx     (dbg_idx),
        .dbg_data    (dbg_data)
    );

    typedef struct packed {
        logic [31:0] ra, rb, rc;
        logic [3:0]  ia, ib, ic;
        logic [4:0]  p1, p2;
        logic [1:0]  sub;
        logic        e0;
    } vec_t;

    localparam logic [31:0] VA  = 32'h8000_0001;
    localparam logic [31:0] VB  = 32'h0000_0010;
    localparam logic [31:0] C1  = 32'hFFFF_FFFF;
    localparam logic [31:0] C0  = 32'hAAAA_AAAA;
    localparam int NV = 10;

    // sub 0 = AND (R2), 1 = OR (R3), 2 = NOR (R4), 3 = AND-NOT (R5)
    localparam vec_t VECS [NV] = '{
        '{VA, VB, C1, 4'd1,  4'd2,  4'd3,  5'd31, 5'd4, 2'd0, 1'b1},
        '{VA, VB, C1, 4'd4,  4'd5,  4'd6,  5'd30, 5'd4, 2'd0, 1'b0},
        '{VA, VB, C1, 4'd14, 4'd15, 4'd0,  5'd30, 5'd4, 2'd1, 1'b1},
        '{VA, VB, C1, 4'd7,  4'd8,  4'd9,  5'd30, 5'd5, 2'd1, 1'b0},
        '{VA, VB, C1, 4'd2,  4'd1,  4'd4,  5'd30, 5'd5, 2'd2, 1'b1},
        '{VA, VB, C1, 4'd3,  4'd6,  4'd5,  5'd0,  5'd5, 2'd2, 1'b0},
        '{VA, VB, C1, 4'd9,  4'd10, 4'd11, 5'd0,  5'd5, 2'd3, 1'b1},
        '{VA, VB, C1, 4'd12, 4'd13, 4'd14, 5'd0,  5'd4, 2'd3, 1'b0},
        '{VA, VB, C0, 4'd1,  4'd2,  4'd3,  5'd31, 5'd4, 2'd0, 1'b0},
        '{VA, VB, C0, 4'd5,  4'd6,  4'd7,  5'd30, 5'd5, 2'd2, 1'b0}
    };

    function automatic logic [31:0] mk(input logic [3:0] c, input logic [4:0] p2,
                                       input logic [1:0] sub, input logic [4:0] p1,
                                       input logic [3:0] b, input logic [3:0] a);
        return {c, p2, sub, p1, b, a, 8'h47};
    endfunction

    function automatic string sub_req(input logic [1:0] s);
        case (s)
            2'd0:    return "R2";
            2'd1:    return "R3";
            2'd2:    return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic load(input logic [3:0] idx, input logic [31:0] val);
        @(negedge clk);
        load_en = 1'b1; load_idx = idx; load_data = val;
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic issue(input logic [31:0] w);
        @(negedge clk);
        instr_valid = 1'b1; instr_word = w;
        @(negedge clk);
        instr_valid = 1'b0;
    endtask

    task automatic peek(input logic [3:0] idx, output logic [31:0] val);
        dbg_idx = idx;
        #1;
        val = dbg_data;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic        all_zero;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R10: reset state
        all_zero = 1'b1;
        for (int i = 0; i < 16; i++) begin
            peek(i[3:0], v);
            if (v !== 32'h0) all_zero = 1'b0;
        end
        chk("R10 regs", {31'h0, all_zero}, 32'h1);
        chk("R10 illegal", {31'h0, illegal_o}, 32'h0);

        // R11: load then debug read
        load(4'd15, 32'hDEAD_BEEF);
        peek(4'd15, v);
        chk("R11", v, 32'hDEAD_BEEF);

        // Table walk: R1 fields, R2..R5 operations, R6 accumulate, R7 upper bits and sources kept
        for (int k = 0; k < NV; k++) begin
            load(VECS[k].ia, VECS[k].ra);
            load(VECS[k].ib, VECS[k].rb);
            load(VECS[k].ic, VECS[k].rc);
            issue(mk(VECS[k].ic, VECS[k].p2, VECS[k].sub, VECS[k].p1, VECS[k].ib, VECS[k].ia));
            peek(VECS[k].ic, v);
            chk(sub_req(VECS[k].sub), v, {VECS[k].rc[31:1], VECS[k].e0});
            peek(VECS[k].ia, v);
            chk("R7 source", v, VECS[k].ra);
        end

        // R6: chain on one destination; once cleared it stays cleared
        load(4'd10, 32'h0000_0011);
        load(4'd11, 32'hFFFF_FFFF);
        load(4'd12, 32'h0000_0000);
        @(negedge clk);
        instr_valid = 1'b1; instr_word = mk(4'd10, 5'd7, 2'd0, 5'd3, 4'd11, 4'd11);
        @(negedge clk);
        peek(4'd10, v);
        chk("R6 hold", v, 32'h0000_0011);
        instr_word = mk(4'd10, 5'd7, 2'd0, 5'd0, 4'd11, 4'd12);
        @(negedge clk);
        instr_word = mk(4'd10, 5'd7, 2'd1, 5'd3, 4'd11, 4'd11);
        @(negedge clk);
        instr_valid = 1'b0;
        peek(4'd10, v);
        chk("R6 sticky", v, 32'h0000_0010);

        // R8: bad opcode flags one cycle, writes nothing
        load(4'd13, 32'h0000_0001);
        @(negedge clk);
        instr_valid = 1'b1;
        instr_word  = {4'd13, 5'd0, 2'd0, 5'd0, 4'd12, 4'd12, 8'h46};
        @(negedge clk);
        instr_valid = 1'b0;
        chk("R8 raised", {31'h0, illegal_o}, 32'h1);
        peek(4'd13, v);
        chk("R8 nowrite", v, 32'h0000_0001);
        @(negedge clk);
        chk("R8 one cycle", {31'h0, illegal_o}, 32'h0);

        // R9: invalid word with a clearing instruction is ignored
        instr_word = mk(4'd13, 5'd0, 2'd0, 5'd0, 4'd12, 4'd12);
        repeat (2) @(negedge clk);
        peek(4'd13, v);
        chk("R9 reg", v, 32'h0000_0001);
        chk("R9 illegal", {31'h0, illegal_o}, 32'h0);

        // R13: destination aliases a source
        load(4'd5, 32'h0000_0003);
        load(4'd6, 32'h0000_0000);
        issue(mk(4'd5, 5'd0, 2'd2, 5'd0, 4'd6, 4'd5));
        peek(4'd5, v);
        chk("R13 c=a", v, 32'h0000_0002);
        load(4'd8, 32'h0000_0001);
        issue(mk(4'd8, 5'd0, 2'd0, 5'd0, 4'd8, 4'd11));
        peek(4'd8, v);
        chk("R13 c=b", v, 32'h0000_0001);

        // R12: flags untouched after all of the above
        chk("R12", {28'h0, flags_o}, 32'h0);

        // R10: reset in mid-run
        load(4'd9, 32'h0000_0005);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        peek(4'd9, v);
        chk("R10 midrun", v, 32'h0);

        summary();
        $finish;
    end

endmodule